// File: doc/BRIEF.md
# Stage-Skipping Multi-Cycle Sequencer

This block drives the control side of a non-pipelined, multi-cycle datapath that is built from eight stages in a fixed order. It takes one instruction at a time. Each opcode visits only the stages it needs, in ascending stage order. Every visited stage takes one clock, and a stage the opcode does not need costs no cycle. An instruction's latency is therefore the number of stages it uses.

A start strobe with an opcode launches an instruction when the sequencer is idle. While the instruction runs, the sequencer marks the current stage on a one-hot vector. It raises a busy flag and pulses done during the final stage. Two 32-bit counters keep totals of retired instructions and of cycles spent with a stage active. Dividing the cycle total by the instruction total gives the CPI of a program. The total time of that program is the cycle total multiplied by the clock period, which the slowest stage sets.

Top module: `stage_seq`

## Requirements
- R1: After synchronous reset, no stage is active, busy, done and the error flag are low, and both counters read zero.
- R2: Stage bit positions are 0=IM1, 1=IM2, 2=DEC, 3=REG, 4=SHFT, 5=ALU, 6=DM1, 7=DM2. At most one stage bit is high, and during one instruction the active bit only moves to higher positions.
- R3: Opcode 0 (add) activates stages 0,2,3,5,7 in consecutive cycles, which is 5 cycles.
- R4: Opcode 1 (sll) activates stages 0,3,4,7, which is 4 cycles.
- R5: Opcode 2 (sw) activates stages 1,2,3,5,6, which is 5 cycles.
- R6: Opcode 3 (lw) activates every stage except 4, which is 7 cycles.
- R7: Opcode 4 (beq) activates stages 0,1,3, which is 3 cycles.
- R8: A start sampled at a clock edge while idle makes the first stage of that opcode active in the next cycle.
- R9: Busy is high exactly while a stage is active, and done is high only in the cycle in which the last stage of an instruction is active.
- R10: A start that arrives while busy (the done cycle included) is ignored. It does not change the stage sequence or the counters.
- R11: A start while idle with opcode 5, 6 or 7 raises the error flag for exactly one cycle, starting the next cycle. It activates no stage and leaves both counters unchanged.
- R12: The cycle counter rises by one after every cycle in which a stage is active. The retired counter rises by one after every done cycle. Both wrap at 32 bits and are cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Launch request, sampled at the clock edge |
| opcodeIn | input | 3 | Opcode that goes with startIn |
| stageActive | output | 8 | One-hot current stage, zero when idle |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Last stage of the instruction is active |
| opError | output | 1 | One-cycle flag for an unsupported opcode |
| retiredCount | output | 32 | Instructions completed |
| cycleCount | output | 32 | Cycles with a stage active |

## Verification
A start sampled at edge k puts the first stage on the vector from edge k, and the sequence then advances one stage per edge. Done coincides with the final stage. The error flag for an unsupported opcode appears one edge after the start. Both counters move one edge after the cycle they count, so retiredCount changes in the first cycle after done. The bench keeps a behavioural model that it advances at each rising edge from the inputs it drove at the preceding falling edge. It compares every output with that model at the next falling edge, so each result is checked in the exact cycle it is due. Per-instruction latency and counter totals over an instruction mix are checked on top of the per-cycle comparison.

// File: rtl/stage_seq_pkg.sv
package stage_seq_pkg;
  localparam int NUM_STAGES = 8;
  localparam int OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SLL = 3'd1,
    OP_SW  = 3'd2,
    OP_LW  = 3'd3,
    OP_BEQ = 3'd4
  } opcode_e;

  // Stage bit positions, ascending in visit order
  localparam int ST_IM1  = 0;
  localparam int ST_IM2  = 1;
  localparam int ST_DEC  = 2;
  localparam int ST_REG  = 3;
  localparam int ST_SHFT = 4;
  localparam int ST_ALU  = 5;
  localparam int ST_DM1  = 6;
  localparam int ST_DM2  = 7;

  typedef struct packed {
    logic tickCycle;
    logic tickRetire;
  } strobe_t;

  // Stages used by each opcode; zero means unsupported
  function automatic logic [NUM_STAGES-1:0] stageMask(input logic [OP_W-1:0] op);
    logic [NUM_STAGES-1:0] m;
    m = '0;
    case (op)
      OP_ADD: begin
        m[ST_IM1] = 1'b1; m[ST_DEC] = 1'b1; m[ST_REG] = 1'b1;
        m[ST_ALU] = 1'b1; m[ST_DM2] = 1'b1;
      end
      OP_SLL: begin
        m[ST_IM1] = 1'b1; m[ST_REG] = 1'b1; m[ST_SHFT] = 1'b1; m[ST_DM2] = 1'b1;
      end
      OP_SW: begin
        m[ST_IM2] = 1'b1; m[ST_DEC] = 1'b1; m[ST_REG] = 1'b1;
        m[ST_ALU] = 1'b1; m[ST_DM1] = 1'b1;
      end
      OP_LW: begin
        m = '1; m[ST_SHFT] = 1'b0;
      end
      OP_BEQ: begin
        m[ST_IM1] = 1'b1; m[ST_IM2] = 1'b1; m[ST_REG] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/stage_seq_pick.sv
// Isolates the lowest set bit of a vector with a ripple of "seen" flags.
module stage_seq_pick #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [WIDTH-1:0] lowOut
);
  logic [WIDTH:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_pick
    assign lowOut[i]   = vecIn[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | vecIn[i];
  end
endmodule

// File: rtl/stage_seq_ctrl.sv
module stage_seq_ctrl
  import stage_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  startIn,
  input  logic [OP_W-1:0]       opcodeIn,
  output logic [NUM_STAGES-1:0] stageActive,
  output logic                  busy,
  output logic                  done,
  output logic                  opError,
  output strobe_t               strobes
);
  logic [NUM_STAGES-1:0] pendMask;
  logic [NUM_STAGES-1:0] launchMask;
  logic [NUM_STAGES-1:0] launchLow;
  logic [NUM_STAGES-1:0] pendLow;
  logic                  opValid;

  assign launchMask = stageMask(opcodeIn);
  assign opValid    = |launchMask;

  stage_seq_pick #(.WIDTH(NUM_STAGES)) u_pickLaunch (.vecIn(launchMask), .lowOut(launchLow));
  stage_seq_pick #(.WIDTH(NUM_STAGES)) u_pickPend   (.vecIn(pendMask),   .lowOut(pendLow));

  assign busy = |stageActive;
  assign done = busy && (pendMask == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stageActive <= '0;
      pendMask    <= '0;
      opError     <= 1'b0;
    end else begin
      opError <= 1'b0;
      if (busy) begin
        stageActive <= pendLow;
        pendMask    <= pendMask & ~pendLow;
      end else if (startIn) begin
        if (opValid) begin
          stageActive <= launchLow;
          pendMask    <= launchMask & ~launchLow;
        end else begin
          opError <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.tickCycle  = busy;
    strobes.tickRetire = done;
  end
endmodule

// File: rtl/stage_seq_dp.sv
module stage_seq_dp
  import stage_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  output logic [CNT_W-1:0] retiredCount,
  output logic [CNT_W-1:0] cycleCount
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      retiredCount <= '0;
      cycleCount   <= '0;
    end else begin
      if (strobes.tickCycle)  cycleCount   <= cycleCount + ONE;
      if (strobes.tickRetire) retiredCount <= retiredCount + ONE;
    end
  end
endmodule

// File: rtl/stage_seq.sv
module stage_seq
  import stage_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  startIn,
  input  logic [OP_W-1:0]       opcodeIn,
  output logic [NUM_STAGES-1:0] stageActive,
  output logic                  busy,
  output logic                  done,
  output logic                  opError,
  output logic [CNT_W-1:0]      retiredCount,
  output logic [CNT_W-1:0]      cycleCount
);
  strobe_t strobes;

  stage_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startIn(startIn), .opcodeIn(opcodeIn),
    .stageActive(stageActive), .busy(busy), .done(done),
    .opError(opError), .strobes(strobes)
  );

  stage_seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .retiredCount(retiredCount), .cycleCount(cycleCount)
  );
endmodule

// File: rtl/stage_seq_chk.sv
module stage_seq_chk
  import stage_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  startIn,
  input logic [NUM_STAGES-1:0] stageActive,
  input logic                  busy,
  input logic                  done,
  input logic                  opError,
  input logic [CNT_W-1:0]      retiredCount,
  input logic [CNT_W-1:0]      cycleCount
);
  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst) $onehot0(stageActive)); // R2
  AST_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (stageActive > $past(stageActive))); // R2
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> busy); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |=> !busy); // R9
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && startIn) |=> busy); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst) opError |=> !opError); // R11
  AST_ERR_NOSTAGE: assert property (@(posedge clk) disable iff (rst)
    opError |-> (stageActive == '0)); // R11
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cycleCount == $past(cycleCount) + CNT_W'(1))); // R12
  AST_RET_STEP: assert property (@(posedge clk) disable iff (rst)
    done |=> (retiredCount == $past(retiredCount) + CNT_W'(1))); // R12
  AST_RET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(retiredCount)); // R12
endmodule

bind stage_seq stage_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .startIn(startIn), .stageActive(stageActive),
  .busy(busy), .done(done), .opError(opError),
  .retiredCount(retiredCount), .cycleCount(cycleCount)
);

// File: tb/sim_stage_seq.sv
module sim_stage_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startIn = 1'b0;
  logic [2:0]  opcodeIn = 3'd0;
  logic [7:0]  stageActive;
  logic        busy, done, opError;
  logic [31:0] retiredCount, cycleCount;

  int    total = 0;
  int    bad = 0;
  string curTag = "R1";

  // behavioural reference
  int    q[$];
  int    expCur = -1;
  bit    expErr = 0;
  int    expRet = 0;
  int    expCyc = 0;
  int    wd = 0;
  bit    finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stage_seq u0 (
    .clk(clk), .rst(rst), .startIn(startIn), .opcodeIn(opcodeIn),
    .stageActive(stageActive), .busy(busy), .done(done), .opError(opError),
    .retiredCount(retiredCount), .cycleCount(cycleCount)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit wasBusy;
    if (rst) begin
      q = {}; expCur = -1; expErr = 0; expRet = 0; expCyc = 0;
    end else begin
      wasBusy = (expCur >= 0);
      expErr = 0;
      if (wasBusy) begin
        expCyc++;
        if (q.size() == 0) begin expRet++; expCur = -1; end
        else expCur = q.pop_front();
      end else if (startIn) begin
        case (opcodeIn)
          3'd0: q = '{0, 2, 3, 5, 7};
          3'd1: q = '{0, 3, 4, 7};
          3'd2: q = '{1, 2, 3, 5, 6};
          3'd3: q = '{0, 1, 2, 3, 5, 6, 7};
          3'd4: q = '{0, 1, 3};
          default: q = {};
        endcase
        if (q.size() == 0) expErr = 1;
        else expCur = q.pop_front();
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] expVec;
    if (!rst && !finished) begin
      expVec = (expCur < 0) ? 8'h00 : (8'h01 << expCur);
      chk(stageActive == expVec, curTag, "stageActive", stageActive, expVec);
      chk(busy == (expCur >= 0), "R9", "busy", busy, expCur >= 0);
      chk(done == (expCur >= 0 && q.size() == 0), "R9", "done", done,
          expCur >= 0 && q.size() == 0);
      chk(opError == expErr, "R11", "opError", opError, expErr);
      chk(cycleCount == 32'(expCyc), "R12", "cycleCount", cycleCount, expCyc);
      chk(retiredCount == 32'(expRet), "R12", "retiredCount", retiredCount, expRet);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runOp(input int op, input string tag, input int expLat);
    int lat;
    int doneAt;
    curTag = tag;
    lat = 0; doneAt = -1;
    @(negedge clk); startIn = 1'b1; opcodeIn = 3'(op);
    @(negedge clk); startIn = 1'b0;
    chk(busy == 1'b1, "R8", "busy one cycle after start", busy, 1);
    while (busy) begin
      if (done) doneAt = lat;
      lat++;
      @(negedge clk);
    end
    chk(lat == expLat, tag, "latency", lat, expLat);
    chk(doneAt == expLat - 1, "R9", "done position", doneAt, expLat - 1);
  endtask

  initial begin
    int r0, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    curTag = "R1";
    chk(stageActive == 8'h00, "R1", "reset stage", stageActive, 0);
    chk(busy == 0 && done == 0 && opError == 0, "R1", "reset flags", {busy, done, opError}, 0);
    chk(retiredCount == 0 && cycleCount == 0, "R1", "reset counters", retiredCount, 0);

    runOp(0, "R3", 5);
    runOp(1, "R4", 4);
    runOp(2, "R5", 5);
    runOp(3, "R6", 7);
    runOp(4, "R7", 3);

    // R10: start while busy is ignored
    curTag = "R10";
    r0 = int'(retiredCount); c0 = int'(cycleCount);
    @(negedge clk); startIn = 1'b1; opcodeIn = 3'd4;
    @(negedge clk); startIn = 1'b0;
    @(negedge clk); startIn = 1'b1; opcodeIn = 3'd3;
    @(negedge clk); startIn = 1'b0;
    while (!done) @(negedge clk);
    startIn = 1'b1; opcodeIn = 3'd0;
    @(negedge clk); startIn = 1'b0;
    chk(busy == 1'b0, "R10", "start in done cycle ignored", busy, 0);
    chk(int'(retiredCount) - r0 == 1, "R10", "one retire", int'(retiredCount) - r0, 1);
    chk(int'(cycleCount) - c0 == 3, "R10", "cycles of beq only", int'(cycleCount) - c0, 3);

    // R11: unsupported opcodes
    for (int op = 5; op < 8; op++) begin
      curTag = "R11";
      r0 = int'(retiredCount); c0 = int'(cycleCount);
      @(negedge clk); startIn = 1'b1; opcodeIn = 3'(op);
      @(negedge clk); startIn = 1'b0;
      chk(opError == 1'b1, "R11", "error raised", opError, 1);
      chk(stageActive == 8'h00, "R11", "no stage", stageActive, 0);
      @(negedge clk);
      chk(opError == 1'b0, "R11", "error one cycle", opError, 0);
      chk(int'(retiredCount) == r0 && int'(cycleCount) == c0, "R11", "counters unchanged",
          cycleCount, c0);
    end

    // R12 / R2: instruction mix totals
    r0 = int'(retiredCount); c0 = int'(cycleCount);
    for (int k = 0; k < 3; k++) begin
      runOp(0, "R3", 5); runOp(3, "R6", 7); runOp(1, "R4", 4);
      runOp(4, "R7", 3); runOp(2, "R5", 5); runOp(0, "R2", 5);
    end
    chk(int'(retiredCount) - r0 == 18, "R12", "mix retired", int'(retiredCount) - r0, 18);
    chk(int'(cycleCount) - c0 == 87, "R12", "mix cycles", int'(cycleCount) - c0, 87);

    // R1: reset mid-instruction clears everything
    @(negedge clk); startIn = 1'b1; opcodeIn = 3'd3;
    @(negedge clk); startIn = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(stageActive == 8'h00 && !busy, "R1", "reset mid-run stage", stageActive, 0);
    chk(cycleCount == 0 && retiredCount == 0, "R1", "reset mid-run counters", cycleCount, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule